// File: doc/BRIEF.md
# Coprocessor Interrupt Pending Controller

This block holds the eight interrupt-pending lines of a processor's system-control coprocessor and decides, from those lines and a status word, whether an interrupt request is sent to the pipeline. External sources raise or drop single lines by index, and one command drops every line at once. An index outside the eight lines has no effect on the lines and raises an error flag.

A free-running 32-bit counter and a compare register form an on-chip timer. When the two are equal and the counter is not zero, the timer sets one pending line. A 3-bit routing field picks that line. Writing the compare register drops the routed line, which is how software acknowledges the timer.

A small register port gives read and write access to the status word, the compare value, the routing field, the pending lines and the counter. The request output is registered. A second output shows whether any line is pending, whatever the mask and gating bits say.

Top module: `irq_pend_ctrl`

## Requirements
- R1: A post with a legal index n (0..7) sets pending bit n and leaves the other seven bits unchanged; it wins over a clear-all in the same cycle.
- R2: A clear with a legal index n clears only pending bit n; a clear-all sets all eight pending bits to zero.
- R3: A post or clear whose 4-bit index is 8..15 leaves the pending bits unchanged, and `idx_err` is 1 in the cycle after that command (0 otherwise).
- R4: When a post and a clear name the same bit in the same cycle, the bit ends up set.
- R5: `irq_req` is registered and equals, one cycle late, IE and not EXL and not ERL and (mask AND pending) nonzero, where the status word holds IE in bit 0, EXL in bit 1, ERL in bit 2 and the 8-bit mask in bits 15:8, mask bit i matching pending bit i.
- R6: `any_pend` is 1 exactly when at least one pending bit is set, regardless of mask, IE, EXL or ERL.
- R7: The counter adds one on each cycle with `tick_en` high and wraps from 0xFFFFFFFF to 0.
- R8: When counter equals compare and the counter is nonzero, the pending bit selected by the 3-bit routing field is set on the next clock edge.
- R9: Counter and compare both zero never set the routed pending bit.
- R10: A write to compare clears the routed pending bit, unless a timer match is present in that same cycle, in which case the bit stays set.
- R11: Register select codes: 0 status (32 bits), 1 compare (32 bits), 2 routing field (bits 2:0), 3 pending bits (bits 7:0), 4 counter (32 bits); writes take effect at the clock edge and `rd_data` shows the selected register combinationally, unused bits reading zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter increment enable |
| post_vld | input | 1 | Post command valid |
| post_idx | input | 4 | Line index for post |
| clr_vld | input | 1 | Clear command valid |
| clr_idx | input | 4 | Line index for clear |
| clr_all | input | 1 | Clear every pending line |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for write |
| wr_data | input | 32 | Register write data |
| rd_sel | input | 3 | Register select for read |
| rd_data | output | 32 | Selected register value |
| irq_req | output | 1 | Registered interrupt request |
| any_pend | output | 1 | Some pending bit is set |
| idx_err | output | 1 | Illegal index seen last cycle |

## Verification
Commands, register writes and timer matches change the pending bits, counter and registers at the next clock edge. `idx_err` follows that same edge. `irq_req` needs one more edge because it is computed from the registered pending bits and status. The bench drives inputs on the falling edge and samples on the following falling edge for register results. For the request it first checks the old value one falling edge after the stimulus, then the new value one edge later, so a request that arrived too early or too late is caught. The timer cases add one idle cycle after the counter write, so the match is seen on the edge after equality is set up.

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl #(
  parameter int NLINES  = 8,
  parameter int IDX_W   = 4,
  parameter int CNT_W   = 32,
  parameter int SEL_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             post_vld,
  input  logic [IDX_W-1:0] post_idx,
  input  logic             clr_vld,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic             clr_all,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [CNT_W-1:0] rd_data,
  output logic             irq_req,
  output logic             any_pend,
  output logic             idx_err
);
  localparam int LW = $clog2(NLINES);
  localparam logic [SEL_W-1:0] SEL_STAT  = SEL_W'(0);
  localparam logic [SEL_W-1:0] SEL_CMP   = SEL_W'(1);
  localparam logic [SEL_W-1:0] SEL_ROUTE = SEL_W'(2);
  localparam logic [SEL_W-1:0] SEL_PEND  = SEL_W'(3);
  localparam logic [SEL_W-1:0] SEL_CNT   = SEL_W'(4);
  localparam int B_IE = 0, B_EXL = 1, B_ERL = 2, B_MASK = 8;

  logic [CNT_W-1:0]  stat_q, cmp_q, cnt_q;
  logic [LW-1:0]     route_q;
  logic [NLINES-1:0] pend_q, pend_d;
  logic              irq_q, err_q;

  wire post_ok = post_vld && (post_idx < IDX_W'(NLINES));
  wire clr_ok  = clr_vld  && (clr_idx  < IDX_W'(NLINES));
  wire cmp_wr  = wr_en && (wr_sel == SEL_CMP);
  wire tmr_hit = (cnt_q == cmp_q) && (cnt_q != '0);
  wire [NLINES-1:0] mask = stat_q[B_MASK +: NLINES];
  wire gate_ok = stat_q[B_IE] && !stat_q[B_EXL] && !stat_q[B_ERL];

  always_comb begin
    pend_d = pend_q;
    if (wr_en && wr_sel == SEL_PEND) pend_d = wr_data[NLINES-1:0];
    if (cmp_wr)  pend_d[route_q] = 1'b0;
    if (clr_all) pend_d = '0;
    if (clr_ok)  pend_d[clr_idx[LW-1:0]] = 1'b0;
    if (post_ok) pend_d[post_idx[LW-1:0]] = 1'b1;
    if (tmr_hit) pend_d[route_q] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q  <= '0;
      cmp_q   <= '0;
      cnt_q   <= '0;
      route_q <= '0;
      pend_q  <= '0;
      irq_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      pend_q <= pend_d;
      irq_q  <= gate_ok && |(mask & pend_q);
      err_q  <= (post_vld && !post_ok) || (clr_vld && !clr_ok);
      if (wr_en && wr_sel == SEL_STAT)  stat_q  <= wr_data;
      if (cmp_wr)                       cmp_q   <= wr_data;
      if (wr_en && wr_sel == SEL_ROUTE) route_q <= wr_data[LW-1:0];
      if (wr_en && wr_sel == SEL_CNT)   cnt_q   <= wr_data;
      else if (tick_en)                 cnt_q   <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    case (rd_sel)
      SEL_STAT:  rd_data = stat_q;
      SEL_CMP:   rd_data = cmp_q;
      SEL_ROUTE: rd_data = CNT_W'(route_q);
      SEL_PEND:  rd_data = CNT_W'(pend_q);
      SEL_CNT:   rd_data = cnt_q;
      default:   rd_data = '0;
    endcase
  end

  assign irq_req  = irq_q;
  assign any_pend = |pend_q;
  assign idx_err  = err_q;
endmodule

// File: rtl/irq_pend_ctrl_chk.sv
module irq_pend_ctrl_chk #(
  parameter int NLINES = 8,
  parameter int IDX_W  = 4,
  parameter int CNT_W  = 32,
  parameter int SEL_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             post_vld,
  input logic [IDX_W-1:0] post_idx,
  input logic             clr_vld,
  input logic [IDX_W-1:0] clr_idx,
  input logic             wr_en,
  input logic [SEL_W-1:0] wr_sel,
  input logic             irq_req,
  input logic             idx_err,
  input logic [CNT_W-1:0] stat_q,
  input logic [CNT_W-1:0] cmp_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [$clog2(NLINES)-1:0] route_q,
  input logic [NLINES-1:0] pend_q
);
  localparam int LW = $clog2(NLINES);

  p_post_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (post_vld && post_idx < IDX_W'(NLINES)) |=> pend_q[$past(post_idx[LW-1:0])]);

  p_bad_idx_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((post_vld && post_idx >= IDX_W'(NLINES)) || (clr_vld && clr_idx >= IDX_W'(NLINES))) |=> idx_err);

  p_err_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[1] || stat_q[2] || !stat_q[0]) |=> !irq_req);

  p_req_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> $past(|(stat_q[8 +: NLINES] & pend_q)));

  p_cnt_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && cnt_q == '1 && !(wr_en && wr_sel == SEL_W'(4))) |=> cnt_q == '0);

  p_timer_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == cmp_q && cnt_q != '0) |=> pend_q[$past(route_q)]);
endmodule

bind irq_pend_ctrl irq_pend_ctrl_chk #(
  .NLINES(NLINES), .IDX_W(IDX_W), .CNT_W(CNT_W), .SEL_W(SEL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
  .post_vld(post_vld), .post_idx(post_idx),
  .clr_vld(clr_vld), .clr_idx(clr_idx),
  .wr_en(wr_en), .wr_sel(wr_sel),
  .irq_req(irq_req), .idx_err(idx_err),
  .stat_q(stat_q), .cmp_q(cmp_q), .cnt_q(cnt_q),
  .route_q(route_q), .pend_q(pend_q)
);

// File: tb/irq_pend_ctrl_test.sv
`timescale 1ns/1ps
module irq_pend_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        post_vld = 1'b0, clr_vld = 1'b0, clr_all = 1'b0, wr_en = 1'b0;
  logic [3:0]  post_idx = '0, clr_idx = '0;
  logic [2:0]  wr_sel = '0, rd_sel = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq_req, any_pend, idx_err;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  irq_pend_ctrl uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .post_vld(post_vld), .post_idx(post_idx),
    .clr_vld(clr_vld), .clr_idx(clr_idx), .clr_all(clr_all),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data),
    .irq_req(irq_req), .any_pend(any_pend), .idx_err(idx_err)
  );

  always #4 clk = ~clk;

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    post_vld = 0; clr_vld = 0; clr_all = 0; wr_en = 0; tick_en = 0;
  endtask

  task automatic reg_wr(logic [2:0] sel, logic [31:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    idle_cycle();
  endtask

  task automatic reg_rd(logic [2:0] sel, output logic [31:0] d);
    rd_sel = sel; #1; d = rd_data;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    reg_rd(3, v); check("R11 reset pend", v, 0);
    reg_rd(4, v); check("R11 reset count", v, 0);
    check("R5 reset irq", irq_req, 0);
    check("R6 reset any_pend", any_pend, 0);
    check("R3 reset err", idx_err, 0);
  endtask

  task automatic t_post_clear();
    logic [31:0] v;
    post_vld = 1; post_idx = 3; idle_cycle();
    reg_rd(3, v); check("R1 post 3", v, 32'h08);
    post_vld = 1; post_idx = 6; idle_cycle();
    reg_rd(3, v); check("R1 post 6 keeps 3", v, 32'h48);
    clr_vld = 1; clr_idx = 3; idle_cycle();
    reg_rd(3, v); check("R2 clear 3", v, 32'h40);
    post_vld = 1; post_idx = 0; clr_all = 1; idle_cycle();
    reg_rd(3, v); check("R1 post beats clear-all", v, 32'h01);
    clr_all = 1; idle_cycle();
    reg_rd(3, v); check("R2 clear-all", v, 0);
  endtask

  task automatic t_bad_idx();
    logic [31:0] v;
    reg_wr(3, 32'h24);
    post_vld = 1; post_idx = 9; idle_cycle();
    reg_rd(3, v); check("R3 post 9 no change", v, 32'h24);
    check("R3 err after post 9", idx_err, 1);
    clr_vld = 1; clr_idx = 12; idle_cycle();
    reg_rd(3, v); check("R3 clear 12 no change", v, 32'h24);
    check("R3 err after clear 12", idx_err, 1);
    idle_cycle();
    check("R3 err drops", idx_err, 0);
  endtask

  task automatic t_same_bit();
    logic [31:0] v;
    reg_wr(3, 0);
    post_vld = 1; post_idx = 2; clr_vld = 1; clr_idx = 2; idle_cycle();
    reg_rd(3, v); check("R4 post beats clear", v, 32'h04);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    reg_wr(3, 0);
    reg_wr(0, 32'h0000_0801);
    reg_rd(0, v); check("R11 status readback", v, 32'h0801);
    idle_cycle();
    post_vld = 1; post_idx = 3; idle_cycle();
    check("R5 irq not yet", irq_req, 0);
    check("R6 any_pend", any_pend, 1);
    idle_cycle();
    check("R5 irq raised", irq_req, 1);
    reg_wr(0, 32'h0000_0805);
    check("R5 irq before ERL seen", irq_req, 1);
    idle_cycle();
    check("R5 ERL blocks", irq_req, 0);
    reg_wr(0, 32'h0000_0803); idle_cycle();
    check("R5 EXL blocks", irq_req, 0);
    reg_wr(0, 32'h0000_0800); idle_cycle();
    check("R5 IE low blocks", irq_req, 0);
    reg_wr(0, 32'h0000_1001); idle_cycle();
    check("R5 masked off", irq_req, 0);
    check("R6 any_pend while masked", any_pend, 1);
    clr_all = 1; idle_cycle();
    check("R6 any_pend clear", any_pend, 0);
    reg_wr(0, 0);
  endtask

  task automatic t_timer();
    logic [31:0] v;
    reg_wr(2, 5);
    reg_rd(2, v); check("R11 route readback", v, 5);
    reg_wr(1, 10);
    reg_wr(4, 10);
    reg_rd(3, v); check("R8 not yet", v, 0);
    idle_cycle();
    reg_rd(3, v); check("R8 timer sets bit 5", v, 32'h20);
    reg_wr(1, 20);
    reg_rd(3, v); check("R10 match same cycle keeps bit", v, 32'h20);
    reg_wr(1, 20);
    reg_rd(3, v); check("R10 compare write acks", v, 0);
    reg_wr(4, 0);
    reg_wr(1, 0);
    idle_cycle(); idle_cycle();
    reg_rd(3, v); check("R9 zero no match", v, 0);
  endtask

  task automatic t_count();
    logic [31:0] v;
    reg_wr(1, 32'h100);
    reg_wr(4, 0);
    tick_en = 1; @(negedge clk); @(negedge clk); @(negedge clk); tick_en = 0;
    reg_rd(4, v); check("R7 count 3", v, 3);
    reg_wr(4, 32'hFFFF_FFFF);
    tick_en = 1; idle_cycle();
    reg_rd(4, v); check("R7 wrap", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_post_clear();
    t_bad_idx();
    t_same_bit();
    t_irq();
    t_timer();
    t_count();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule